// File: doc/BRIEF.md
# Processor Power-Mode Register Unit

This unit is the register-level half of a processor speed-tuning interface. Software on a management bus writes a 32-bit control word. The top bit of the word picks one of two stored control halves. The low half holds a requested speed ratio, a request-valid flag and several timing fields. When a valid request asks for a speed other than the current one, the unit raises a "received" flag. It then counts out a transition delay set by a field of the request, and finally raises a "completed" flag and switches its current speed.

The current speed drives a 2-bit ratio select to a downstream clock divider (0 for 1:1, 1 for 1:2, 2 for 1:4). A separate strobe stays high while a transition is in flight. A 64-bit status word at its own address reports the two handshake flags and the current speed. Clock generation, voltage ramping and analog slewing are handled elsewhere.

Top module: `pmcu_top`

## Requirements
- R1: While reset is asserted, and after it is released with no write, the control address reads 0, the status address reads 0, `ratio_sel` is 0 and `req_active` is 0. A reset in the middle of a transition also returns the unit to this state.
- R2: A write to the control address with bit 31 = 1 stores bits 30:0 into the low half, read back on `mgmt_rdata[30:0]`. With bit 31 = 0 it stores bits 30:0 into the high half, read back on `mgmt_rdata[62:32]`. Bits 63 and 31 read 0, and the other half is unchanged.
- R3: Every bit of the low half is stored and read back unchanged. This includes the target-time field (bits 14:13), the voltage-valid flag (bit 15), the latency fields (bits 12:0) and a speed field written without a request.
- R4: A low-half write starts a transition when four conditions hold: the payload is non-zero, bit 16 is 1, the speed field in bits 19:17 is 0, 1 or 2, and that speed differs from the current speed. On the following cycle, status bit 61 (received) is 1, status bit 60 (completed) is 0 and `req_active` is 1.
- R5: A started transition keeps bit 61 set for exactly BASE_CYC×(T+1) cycles, where T is bits 14:13 of the request. The next cycle shows bit 61 = 0, bit 60 = 1, status bits 57:56 equal to the requested speed, and `ratio_sel` equal to that speed.
- R6: A low-half write does not start a transition if bit 16 is clear, the speed field is 3 to 7, or the speed equals the current speed. The status word is then unchanged.
- R7: An all-zero payload clears the selected half and starts no transition.
- R8: A low-half write during a transition is stored but does not change the target speed or the remaining delay, and it is not queued for later.
- R9: Writes to the status address change neither the status nor the control halves. Any other address reads 0.
- R10: `ratio_sel` always equals status bits 57:56, and `req_active` always equals status bit 61.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_we | input | 1 | Write strobe, sampled on the rising edge |
| mgmt_addr | input | ADDR_W | Register address for reads and writes |
| mgmt_wdata | input | 32 | Write data; bit 31 selects the control half |
| mgmt_rdata | output | 64 | Combinational read data for `mgmt_addr` |
| ratio_sel | output | 2 | Current speed ratio to the clock divider |
| req_active | output | 1 | High while a transition is in flight |

## Verification
The bench counts the delay at both its short and its long setting and samples the status on the last busy cycle and on the first completed cycle. An off-by-one counter therefore shows up as an early or late completion. It sends requests that must be ignored: a repeated speed, an illegal speed code, a write without the valid flag, and a write that arrives mid-transition. A design that retargets or re-arms on any of these would change the reported speed or raise the received flag again. All-zero writes and writes to the status address check that halves clear without side effects and that the status word cannot be overwritten. A reset during a transition checks that no flag or half survives.

// File: rtl/pmcu_pkg.sv
`timescale 1ns/1ps
package pmcu_pkg;
    localparam int CTRL_W        = 32;
    localparam int HALF_W        = CTRL_W - 1;
    localparam int STAT_W        = 64;
    localparam int SEL_BIT       = 31;
    localparam int SPD_LSB       = 17;
    localparam int SPD_W         = 3;
    localparam int FREQ_VLD_BIT  = 16;
    localparam int TT_LSB        = 13;
    localparam int TT_W          = 2;
    localparam int STAT_RCV_BIT  = 61;
    localparam int STAT_CMP_BIT  = 60;
    localparam int STAT_SPD_LSB  = 56;

    typedef enum logic [1:0] {
        SPD_FULL    = 2'd0,
        SPD_HALF    = 2'd1,
        SPD_QUARTER = 2'd2
    } speed_e;
endpackage

// File: rtl/pmcu_regfile.sv
`timescale 1ns/1ps
module pmcu_regfile
    import pmcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } halves_t;

    halves_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (wr_lo) rf_d.lo = wdata;
        if (wr_hi) rf_d.hi = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign lo_o = rf_q.lo;
    assign hi_o = rf_q.hi;

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> $stable(rf_q.lo)); // R2
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> $stable(rf_q.hi)); // R2
endmodule

// File: rtl/pmcu_xition.sv
`timescale 1ns/1ps
module pmcu_xition
    import pmcu_pkg::*;
#(
    parameter int BASE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [HALF_W-1:0] req_word,
    output logic              rcv_o,
    output logic              cmp_o,
    output logic [1:0]        cur_o
);
    localparam int MAX_D = BASE_CYC * (2 ** TT_W);
    localparam int CNT_W = $clog2(MAX_D + 1);

    typedef struct packed {
        logic             rcv;
        logic             cmp;
        logic [1:0]       cur;
        logic [1:0]       tgt;
        logic [CNT_W-1:0] cnt;
    } xst_t;

    xst_t             st_d, st_q;
    logic [SPD_W-1:0] spd_req;
    logic [TT_W-1:0]  tt_req;
    logic [CNT_W-1:0] dly_m1;
    logic             start;

    always_comb begin
        spd_req = req_word[SPD_LSB +: SPD_W];
        tt_req  = req_word[TT_LSB +: TT_W];
        dly_m1  = CNT_W'(BASE_CYC) * (CNT_W'(tt_req) + CNT_W'(1)) - CNT_W'(1);
        start   = req_wr && (req_word != '0) && req_word[FREQ_VLD_BIT]
                  && (spd_req <= SPD_W'(SPD_QUARTER))
                  && (spd_req[1:0] != st_q.cur) && !st_q.rcv;
        st_d = st_q;
        if (st_q.rcv) begin
            if (st_q.cnt == '0) begin
                st_d.rcv = 1'b0;
                st_d.cmp = 1'b1;
                st_d.cur = st_q.tgt;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (start) begin
            st_d.rcv = 1'b1;
            st_d.cmp = 1'b0;
            st_d.tgt = spd_req[1:0];
            st_d.cnt = dly_m1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rcv_o = st_q.rcv;
    assign cmp_o = st_q.cmp;
    assign cur_o = st_q.cur;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rcv && st_q.cmp)); // R4
    AST_START_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.rcv && !st_q.cmp)); // R4
    AST_SPEED_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur != $past(st_q.cur)) |-> (st_q.cmp && $past(st_q.rcv))); // R5
    AST_SPEED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cur != 2'd3); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rcv |-> (st_q.cnt < CNT_W'(MAX_D))); // R5
    AST_BUSY_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rcv && req_wr) |=> $stable(st_q.tgt)); // R8
endmodule

// File: rtl/pmcu_top.sv
`timescale 1ns/1ps
module pmcu_top
    import pmcu_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'h8,
    parameter int                BASE_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_we,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic [CTRL_W-1:0] mgmt_wdata,
    output logic [STAT_W-1:0] mgmt_rdata,
    output logic [1:0]        ratio_sel,
    output logic              req_active
);
    logic              ctrl_hit, wr_lo, wr_hi;
    logic [HALF_W-1:0] lo_w, hi_w;
    logic              rcv_w, cmp_w;
    logic [1:0]        cur_w;
    logic [STAT_W-1:0] stat_word;

    always_comb begin
        ctrl_hit = (mgmt_addr == CTRL_ADDR);
        wr_lo    = mgmt_we && ctrl_hit && mgmt_wdata[SEL_BIT];
        wr_hi    = mgmt_we && ctrl_hit && !mgmt_wdata[SEL_BIT];
        stat_word = '0;
        stat_word[STAT_RCV_BIT] = rcv_w;
        stat_word[STAT_CMP_BIT] = cmp_w;
        stat_word[STAT_SPD_LSB +: 2] = cur_w;
        if (ctrl_hit)                    mgmt_rdata = {1'b0, hi_w, 1'b0, lo_w};
        else if (mgmt_addr == STAT_ADDR) mgmt_rdata = stat_word;
        else                             mgmt_rdata = '0;
    end

    pmcu_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (mgmt_wdata[HALF_W-1:0]),
        .lo_o  (lo_w),
        .hi_o  (hi_w)
    );

    pmcu_xition #(.BASE_CYC(BASE_CYC)) u_xition (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_wr   (wr_lo),
        .req_word (mgmt_wdata[HALF_W-1:0]),
        .rcv_o    (rcv_w),
        .cmp_o    (cmp_w),
        .cur_o    (cur_w)
    );

    assign ratio_sel  = cur_w;
    assign req_active = rcv_w;

    AST_IDLE_RATIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!req_active) && !req_active) |-> $stable(ratio_sel)); // R6
endmodule

// File: tb/pmcu_top_tb_top.sv
`timescale 1ns/1ps
module pmcu_top_tb_top;
    localparam int         BASE = 4;
    localparam logic [3:0] CA   = 4'h0;
    localparam logic [3:0] SA   = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_we = 1'b0;
    logic [3:0]  mgmt_addr = 4'h0;
    logic [31:0] mgmt_wdata = 32'h0;
    logic [63:0] mgmt_rdata;
    logic [1:0]  ratio_sel;
    logic        req_active;

    always #2.5 clk = ~clk;

    pmcu_top #(.ADDR_W(4), .CTRL_ADDR(CA), .STAT_ADDR(SA), .BASE_CYC(BASE)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mgmt_we    (mgmt_we),
        .mgmt_addr  (mgmt_addr),
        .mgmt_wdata (mgmt_wdata),
        .mgmt_rdata (mgmt_rdata),
        .ratio_sel  (ratio_sel),
        .req_active (req_active)
    );

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sbq[$];
    item_t       mon_it;
    logic [63:0] mon_act;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            mon_it = sbq.pop_front();
            case (mon_it.kind)
                0:       mon_act = mgmt_rdata;
                1:       mon_act = 64'(ratio_sel);
                default: mon_act = 64'(req_active);
            endcase
            checks++;
            if (mon_act !== mon_it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", mon_it.tag, mon_act, mon_it.exp);
            end
        end
    end

    function automatic logic [63:0] st(input logic r, input logic c, input logic [1:0] s);
        logic [63:0] v = '0;
        v[61] = r;
        v[60] = c;
        v[57:56] = s;
        return v;
    endfunction

    function automatic logic [63:0] cw(input logic [30:0] hi, input logic [30:0] lo);
        return {1'b0, hi, 1'b0, lo};
    endfunction

    function automatic int dly(input int tt);
        return BASE * (tt + 1);
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        mgmt_we = 1'b1; mgmt_addr = a; mgmt_wdata = d;
        @(posedge clk); #1;
        mgmt_we = 1'b0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [63:0] e, input string t);
        item_t x;
        mgmt_addr = a;
        x.kind = 0; x.exp = e; x.tag = t;
        sbq.push_back(x);
    endtask

    task automatic exp_out(input logic [1:0] r, input logic q, input string t);
        item_t x;
        x.kind = 1; x.exp = 64'(r); x.tag = {t, " ratio_sel"};
        sbq.push_back(x);
        x.kind = 2; x.exp = 64'(q); x.tag = {t, " req_active"};
        sbq.push_back(x);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [30:0] hi, lo;
        #1;
        // R1: state while reset is held and after release
        exp_rd(CA, 64'h0, "R1 ctrl in reset"); exp_out(2'd0, 1'b0, "R1 in reset");
        step();
        exp_rd(SA, 64'h0, "R1 status in reset");
        step(); step();
        rst_n = 1'b1;
        step();
        exp_rd(SA, 64'h0, "R1 status after release");
        step();

        // R2: high half written with bit 31 clear
        wr(CA, 32'h1234_5678); hi = 31'h1234_5678; lo = '0;
        exp_rd(CA, cw(hi, lo), "R2 high half write");
        // R3 R6: every low field stored, speed 1 without valid flag starts nothing
        wr(CA, 32'h8002_FFEF); lo = 31'h0002_FFEF;
        exp_rd(CA, cw(hi, lo), "R3 low fields readback");
        step();
        exp_rd(SA, 64'h0, "R6 no valid flag keeps status");
        exp_out(2'd0, 1'b0, "R6 R10 idle");
        step();

        // R4 R5: half-speed request, target time 0
        wr(CA, 32'h8003_0000); lo = 31'h0003_0000;
        exp_rd(SA, st(1, 0, 0), "R4 received set");
        exp_out(2'd0, 1'b1, "R4 R10 busy");
        for (int k = 1; k < dly(0); k++) step();
        exp_rd(SA, st(1, 0, 0), "R5 busy on last delay cycle tt0");
        step();
        exp_rd(SA, st(0, 1, 1), "R5 completed half speed");
        exp_out(2'd1, 1'b0, "R5 R10 done");
        step();

        // R6: same speed again, then illegal speed code 3
        wr(CA, 32'h8003_0000);
        exp_rd(SA, st(0, 1, 1), "R6 same speed ignored");
        step();
        wr(CA, 32'h8007_0000); lo = 31'h0007_0000;
        exp_rd(SA, st(0, 1, 1), "R6 illegal speed ignored");
        step();
        exp_rd(CA, cw(hi, lo), "R3 illegal speed still stored");
        step();

        // R5: quarter speed, target time 2
        wr(CA, 32'h8005_4000); lo = 31'h0005_4000;
        exp_rd(SA, st(1, 0, 1), "R4 received quarter");
        for (int k = 1; k < dly(2); k++) step();
        exp_rd(SA, st(1, 0, 1), "R5 busy on last delay cycle tt2");
        step();
        exp_rd(SA, st(0, 1, 2), "R5 completed quarter speed");
        exp_out(2'd2, 1'b0, "R5 R10 quarter");
        step();

        // R8: back to full, overlapping write during the transition
        wr(CA, 32'h8001_0000);
        wr(CA, 32'h8003_0000); lo = 31'h0003_0000;
        exp_rd(CA, cw(hi, lo), "R8 busy write stored");
        step();
        exp_rd(SA, st(1, 0, 2), "R8 still busy, speed unchanged");
        step();
        exp_rd(SA, st(0, 1, 0), "R8 target kept full speed");
        exp_out(2'd0, 1'b0, "R8 R10 full");
        step(); step();
        exp_rd(SA, st(0, 1, 0), "R8 busy write not queued");
        step();

        // R7: all-zero writes clear halves without a transition
        wr(CA, 32'h8000_0000); lo = '0;
        exp_rd(CA, cw(hi, lo), "R7 low half cleared");
        step();
        exp_rd(SA, st(0, 1, 0), "R7 zero write no transition");
        step();
        wr(CA, 32'h0000_0000); hi = '0;
        exp_rd(CA, cw(hi, lo), "R7 high half cleared");
        step();

        // R9: status is read-only, unmapped reads zero
        wr(SA, 32'hFFFF_FFFF);
        exp_rd(SA, st(0, 1, 0), "R9 status write ignored");
        step();
        exp_rd(CA, 64'h0, "R9 status write leaves control");
        step();
        exp_rd(4'h3, 64'h0, "R9 unmapped read");
        step();

        // R1: reset in the middle of a transition
        wr(CA, 32'h0000_00AA);
        wr(CA, 32'h8005_0000);
        exp_out(2'd0, 1'b1, "R1 busy before reset");
        step();
        rst_n = 1'b0;
        step();
        exp_rd(SA, 64'h0, "R1 status cleared mid transition");
        step();
        exp_rd(CA, 64'h0, "R1 halves cleared");
        exp_out(2'd0, 1'b0, "R1 outputs cleared");
        step();
        rst_n = 1'b1;
        for (int k = 0; k < dly(0) + 2; k++) step();
        exp_rd(SA, 64'h0, "R1 no transition after reset");
        step(); step();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule